// File: doc/BRIEF.md
# Bridge Leg Modulator with Separate Free-Wheel Control

This block generates the two leg-state signals for a full-bridge switch stage. Besides driving the load, that stage steers a line current through its free-wheeling intervals. A free-running counter defines the switching period. In every period, two parameters decide how the period is split. The load term `m` sets the length of each powering phase. The current term `gamma` sets how long the first free-wheel phase lasts. Both are given in counter ticks. Three stacked compare levels are derived from the active parameters: `m`, `gamma+m` and `gamma+2m`. The two leg signals come straight from comparisons of the counter against these levels.

Each period runs through four states in a fixed order:
1. The positive powering phase, with `leg_a` high and `leg_b` low, lasting `m` ticks.
2. An upper free-wheel, with both legs high, lasting `gamma` ticks.
3. The negative powering phase, with `leg_a` low and `leg_b` high, lasting `m` ticks.
4. A lower free-wheel, with both legs low, for the rest of the period.

The two powering phases are equally long, so an isolation transformer behind the bridge always resets its magnetising current. New parameter values are held until the period boundary, so a period is never altered part-way through. A one-cycle strobe marks the first tick of every period and can trigger the current sampling.

Top module: `bridge_pwm`

## Requirements
- R1: The counter runs 0 to PERIOD-1 and wraps. `period_start` is high exactly while the counter is 0: in the first cycle after reset and then once every PERIOD cycles.
- R2: After reset, `leg_a`, `leg_b` and `sat` stay low until the first parameter set takes effect.
- R3: Take the active parameters m and g, and let L2 = min(g+m, PERIOD). `leg_a` is high exactly while the counter is strictly less than L2.
- R4: Let L1 = min(m, PERIOD) and L3 = min(g+2m, PERIOD). `leg_b` is high exactly while L1 <= counter < L3.
- R5: Within a period, `leg_a` rises only at the period start. Once `leg_b` has fallen, `leg_a` is low for the rest of that period.
- R6: When g+2m <= PERIOD, the counts of cycles with (`leg_a`=1, `leg_b`=0) and with (`leg_a`=0, `leg_b`=1) within a period are equal, and both are m.
- R7: `sat` is high while a parameter set is active with g+2m > PERIOD. The positive powering phase is kept at L1 ticks and the later levels are clamped to PERIOD.
- R8: A `ld_valid` pulse in any cycle other than the last of a period does not change the current period. Its values take effect from counter value 0 of the next period.
- R9: A `ld_valid` pulse in the last cycle of a period takes effect in the very next period. When several pulses fall within one period, the last one wins.
- R10: Asserting reset during operation returns the block to the unloaded state of R2, with the counter back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Captures `m_ticks` and `gamma_ticks` for the next period |
| m_ticks | input | $clog2(PERIOD+1) | Powering-phase length in ticks |
| gamma_ticks | input | $clog2(PERIOD+1) | Upper free-wheel length in ticks |
| leg_a | output | 1 | First leg state (upper switch on when high) |
| leg_b | output | 1 | Second leg state (upper switch on when high) |
| period_start | output | 1 | High on the first tick of each period |
| sat | output | 1 | Active parameters exceed the period |

## Verification
The leg outputs, `sat` and `period_start` are decoded from the counter and from registered parameters without further registers. The bench therefore expects each of them in the same cycle as the counter value it belongs to, and samples at the falling edge. A `ld_valid` pulse registers at the following rising edge but has no visible effect until the counter reads 0 again. The bench tracks its position in the period and checks the old pattern up to the wrap and the new pattern from counter 0 onward. A reset release leaves the counter at 0, so the falling edge after release counts as position 0.

// File: rtl/bridge_pwm.sv
module bridge_pwm #(
  parameter int PERIOD = 6250,
  localparam int CW = $clog2(PERIOD),
  localparam int W  = $clog2(PERIOD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic [W-1:0] m_ticks,
  input  logic [W-1:0] gamma_ticks,
  output logic         leg_a,
  output logic         leg_b,
  output logic         period_start,
  output logic         sat
);

  localparam int SW = W + 2;
  localparam logic [SW-1:0] LIM = SW'(PERIOD);

  logic [CW-1:0] cnt;
  logic [W-1:0]  pend_m, pend_g, act_m, act_g;
  logic          pend, armed;

  wire wrap = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend_m <= '0;
      pend_g <= '0;
      act_m  <= '0;
      act_g  <= '0;
      pend   <= 1'b0;
      armed  <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        if (ld_valid) begin
          act_m <= m_ticks;
          act_g <= gamma_ticks;
          armed <= 1'b1;
        end else if (pend) begin
          act_m <= pend_m;
          act_g <= pend_g;
          armed <= 1'b1;
        end
        pend <= 1'b0;
      end else if (ld_valid) begin
        pend_m <= m_ticks;
        pend_g <= gamma_ticks;
        pend   <= 1'b1;
      end
    end
  end

  logic [SW-1:0] lvl1, lvl2, lvl3, c1, c2, c3, cx;

  assign lvl1 = SW'(act_m);
  assign lvl2 = lvl1 + SW'(act_g);
  assign lvl3 = lvl2 + lvl1;
  assign c1   = (lvl1 > LIM) ? LIM : lvl1;
  assign c2   = (lvl2 > LIM) ? LIM : lvl2;
  assign c3   = (lvl3 > LIM) ? LIM : lvl3;
  assign cx   = SW'(cnt);

  assign leg_a        = armed & (cx < c2);
  assign leg_b        = armed & ~(cx < c1) & (cx < c3);
  assign sat          = armed & (lvl3 > LIM);
  assign period_start = (cnt == '0);

endmodule

// File: rtl/bridge_pwm_chk.sv
module bridge_pwm_chk #(
  parameter int PERIOD = 6250
) (
  input logic clk,
  input logic rst_n,
  input logic ld_valid,
  input logic leg_a,
  input logic leg_b,
  input logic period_start,
  input logic sat
);

  int   gap, pos_n, neg_n;
  logic seen, ld_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= 0;
      pos_n   <= 0;
      neg_n   <= 0;
      seen    <= 1'b0;
      ld_seen <= 1'b0;
    end else begin
      if (ld_valid) ld_seen <= 1'b1;
      if (period_start) begin
        gap   <= 0;
        seen  <= 1'b1;
        pos_n <= (leg_a && !leg_b) ? 1 : 0;
        neg_n <= (!leg_a && leg_b) ? 1 : 0;
      end else begin
        gap   <= gap + 1;
        pos_n <= pos_n + ((leg_a && !leg_b) ? 1 : 0);
        neg_n <= neg_n + ((!leg_a && leg_b) ? 1 : 0);
      end
    end
  end

  p_strobe_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && seen) |-> (gap == PERIOD - 1));

  p_idle_until_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_seen |-> (!leg_a && !leg_b && !sat));

  p_a_rises_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg_a) |-> period_start);

  p_b_falls_after_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(leg_b) |-> (!leg_a || period_start));

  p_equal_powering_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && seen && !$past(sat)) |-> (pos_n == neg_n));

endmodule

bind bridge_pwm bridge_pwm_chk #(.PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .leg_a(leg_a),
  .leg_b(leg_b), .period_start(period_start), .sat(sat)
);

// File: tb/bridge_pwm_test.sv
module bridge_pwm_test;

  localparam int P  = 20;
  localparam int W  = $clog2(P + 1);
  localparam int NV = 9;
  localparam int VM [NV] = '{4, 0, 6, 5, 7, 10, 12, 25, 0};
  localparam int VG [NV] = '{3, 5, 0, 10, 8, 5, 0, 0, 0};
  localparam bit VS [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0, ld_valid = 1'b0;
  logic [W-1:0] m_ticks = '0, gamma_ticks = '0;
  logic leg_a, leg_b, period_start, sat;
  int total = 0, bad = 0;

  bridge_pwm #(.PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .m_ticks(m_ticks),
    .gamma_ticks(gamma_ticks), .leg_a(leg_a), .leg_b(leg_b),
    .period_start(period_start), .sat(sat)
  );

  always #4 clk = ~clk;

  function automatic int lim(input int v);
    return (v > P) ? P : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Entered at the falling edge where the counter is 0; leaves at the next such edge.
  task automatic run_period(input int m, input int g, input bit arm, input string tg,
                            input int k1, input int m1, input int g1,
                            input int k2, input int m2, input int g2);
    for (int k = 0; k < P; k++) begin
      bit ea, eb, es;
      ea = arm && (k < lim(g + m));
      eb = arm && (k >= lim(m)) && (k < lim(g + 2 * m));
      es = arm && (g + 2 * m > P);
      chk(leg_a == ea, {tg, " leg_a R3"}, int'(leg_a), int'(ea));
      chk(leg_b == eb, {tg, " leg_b R4"}, int'(leg_b), int'(eb));
      chk(period_start == (k == 0), {tg, " strobe R1"}, int'(period_start), int'(k == 0));
      if (k == 0) chk(sat == es, {tg, " sat R7"}, int'(sat), int'(es));
      ld_valid = 1'b0;
      if (k == k1) begin ld_valid = 1'b1; m_ticks = W'(m1); gamma_ticks = W'(g1); end
      if (k == k2) begin ld_valid = 1'b1; m_ticks = W'(m2); gamma_ticks = W'(g2); end
      @(negedge clk);
    end
    ld_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pm, pg;
    bit parm;
    repeat (3) @(negedge clk);
    chk(!leg_a && !leg_b && !sat, "R2 reset legs", int'({leg_a, leg_b, sat}), 0);
    rst_n = 1'b1;
    run_period(0, 0, 0, "R2", -1, 0, 0, -1, 0, 0);
    pm = 0; pg = 0; parm = 0;
    for (int i = 0; i < NV; i++) begin
      run_period(pm, pg, parm, "R8 old", 5, VM[i], VG[i], -1, 0, 0);
      chk(1'b1, "R7 table", 0, 0);
      run_period(VM[i], VG[i], 1, "R6 R7 new", -1, 0, 0, -1, 0, 0);
      chk((VG[i] + 2 * VM[i] > P) == VS[i], "R7 table sat", int'(VG[i] + 2 * VM[i] > P), int'(VS[i]));
      pm = VM[i]; pg = VG[i]; parm = 1;
    end
    run_period(pm, pg, 1, "R9 last", P - 1, 3, 2, -1, 0, 0);
    run_period(3, 2, 1, "R9 bypass", 2, 2, 2, 9, 5, 1);
    run_period(5, 1, 1, "R9 lastwins", -1, 0, 0, -1, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!leg_a && !leg_b && !sat, "R10 in reset", int'({leg_a, leg_b, sat}), 0);
    rst_n = 1'b1;
    run_period(0, 0, 0, "R10", -1, 0, 0, -1, 0, 0);
    run_period(0, 0, 0, "R10", -1, 0, 0, -1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule